// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator machine. Each operation combines the held accumulator with a second byte, supplied by the surrounding datapath from a register, a memory location or an immediate field. The operation can use the stored carry as an incoming carry or borrow. The block computes a result, decides whether that result goes back into the accumulator, and derives five status bits: sign, zero, auxiliary carry, parity and carry.

The accumulator register and the flag register sit inside the block. They change only on a clock edge where the valid strobe is high. Each operation class has its own rules for accumulator writeback and for flag updates. A compare only sets flags. A move only loads the accumulator. The logic operations force the two carry flags to fixed values. The decoded operation code arrives on `op_i`. The block does not fetch or decode instructions.

Top module: `alu8_core`

## Requirements
- R1: A synchronous active-low reset clears the accumulator and all five flags to zero.
- R2: The accumulator and the flags keep their values on any edge where `valid_i` is low. They also keep their values when `op_i` holds a code above 8. Operation codes: 0 move, 1 add, 2 add with carry, 3 subtract, 4 subtract with borrow, 5 compare, 6 AND, 7 OR, 8 XOR.
- R3: Add and add-with-carry write A+B (+CY for code 2) modulo 256. CY is the carry out of bit 7 and AC is the carry out of bit 3.
- R4: Subtract and subtract-with-borrow write A-B (-CY for code 4) modulo 256. CY is set when B (plus the borrow) exceeds A as unsigned numbers. AC is set when the low nibble of B (plus the borrow) exceeds the low nibble of A.
- R5: Compare sets all flags as a subtract would, never changes the accumulator, and drives `acc_we_o` low.
- R6: AND writes A&B, sets AC and clears CY.
- R7: OR writes A|B and XOR writes A^B. Both clear AC and CY, so XOR of the accumulator with itself gives 00h with Z set.
- R8: For every operation except move, S is bit 7 of the result, Z is set when the result is 00h, and P is set when the result has an even number of 1 bits.
- R9: Move loads the operand into the accumulator and leaves every flag unchanged.
- R10: `result_o` and `acc_we_o` show the result and writeback decision for the present inputs in the same cycle. `flags_o` bit order is CY=0, P=1, AC=2, Z=3, S=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Commit strobe for the present operation |
| op_i | input | 4 | Operation code |
| operand_i | input | 8 | Second operand byte |
| result_o | output | 8 | Combinational operation result |
| acc_we_o | output | 1 | High when the present operation would write the accumulator |
| acc_o | output | 8 | Registered accumulator |
| flags_o | output | 5 | Registered flags {S,Z,AC,P,CY} |

## Verification
On every cycle, the assertions check the following: the registers hold while the strobe is low, a move leaves the flags alone, a compare leaves the accumulator alone, XOR clears both carries, AND leaves AC set and CY clear, and the sign, zero and parity flags agree with the newly written accumulator. The bench scenarios are needed to show the numeric results and the carry and borrow values, including the 87h+79h wrap to zero. They also show that carry chains correctly into add-with-carry and subtract-with-borrow, and that a compare sets flags from a difference that never appears at `acc_o`.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes and flag bit positions for the ALU.
// Assumes the flag vector is packed as {S,Z,AC,P,CY} from bit 4 down.
package alu8_pkg;
    typedef enum logic [3:0] {
        OP_MOV = 4'd0,
        OP_ADD = 4'd1,
        OP_ADC = 4'd2,
        OP_SUB = 4'd3,
        OP_SBB = 4'd4,
        OP_CMP = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8
    } alu_op_e;

    localparam int FLAG_W = 5;
    localparam int FLG_CY = 0;
    localparam int FLG_P  = 1;
    localparam int FLG_AC = 2;
    localparam int FLG_Z  = 3;
    localparam int FLG_S  = 4;
endpackage

// File: rtl/alu8_addsub.sv
// Adder/subtractor: produces a +/- b with carry-in or borrow-in, plus
// the carry/borrow out of the top bit and of the low nibble.
// Assumes sub=1 means borrow semantics on cin, cy_o and ac_o.
module alu8_addsub #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cy_o,
    output logic              ac_o
);
    logic [DATA_W-1:0] b_x;
    logic              c_x;
    logic              c_top;
    logic              c_nib;
    logic [NIB_W-1:0]  nib_unused;

    // Invert operand and carry for two's-complement subtraction.
    always_comb begin
        b_x = sub_i ? ~b_i : b_i;
        c_x = sub_i ? ~cin_i : cin_i;
    end

    // Full-width sum and low-nibble sum; borrow is inverted carry.
    always_comb begin
        {c_top, sum_o}      = {1'b0, a_i} + {1'b0, b_x} + {{DATA_W{1'b0}}, c_x};
        {c_nib, nib_unused} = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_x[NIB_W-1:0]}
                              + {{NIB_W{1'b0}}, c_x};
        cy_o = sub_i ? ~c_top : c_top;
        ac_o = sub_i ? ~c_nib : c_nib;
    end
endmodule

// File: rtl/alu8_logic.sv
// Bitwise unit: AND, OR, XOR with fixed carry-flag outputs.
// Assumes sel_i: 0 AND, 1 OR, 2 XOR; AND sets AC, all clear CY.
module alu8_logic #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [1:0]        sel_i,
    output logic [DATA_W-1:0] res_o,
    output logic              ac_o,
    output logic              cy_o
);
    // Select the bitwise function and its auxiliary-carry value.
    always_comb begin
        cy_o = 1'b0;
        ac_o = 1'b0;
        unique case (sel_i)
            2'd0:    begin res_o = a_i & b_i; ac_o = 1'b1; end
            2'd1:    res_o = a_i | b_i;
            default: res_o = a_i ^ b_i;
        endcase
    end
endmodule

// File: rtl/alu8_szp.sv
// Result-derived flags: sign (top bit), zero, even parity.
// Assumes a result of at least one bit.
module alu8_szp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] res_i,
    output logic              s_o,
    output logic              z_o,
    output logic              p_o
);
    // Derive the three result flags.
    always_comb begin
        s_o = res_i[DATA_W-1];
        z_o = (res_i == '0);
        p_o = ~(^res_i);
    end
endmodule

// File: rtl/alu8_core.sv
// Top: accumulator ALU with accumulator and flag registers.
// Assumes op_i is already decoded; codes above OP_XOR are no-ops.
// Registers change only when valid_i is high; synchronous active-low reset.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic [DATA_W-1:0] result_o,
    output logic              acc_we_o,
    output logic [DATA_W-1:0] acc_o,
    output logic [FLAG_W-1:0] flags_o
);
    logic [DATA_W-1:0] acc_q;
    logic [FLAG_W-1:0] flg_q;
    logic [DATA_W-1:0] as_sum, lg_res;
    logic              as_cy, as_ac, lg_cy, lg_ac;
    logic              is_sub, use_cin, cin;
    logic [1:0]        lg_sel;
    logic              f_s, f_z, f_p;
    logic              flg_we;
    logic              nxt_cy, nxt_ac;
    alu_op_e           op;

    // Decode operation class and carry source.
    always_comb begin
        op      = alu_op_e'(op_i);
        is_sub  = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        use_cin = (op == OP_ADC) || (op == OP_SBB);
        cin     = use_cin & flg_q[FLG_CY];
        lg_sel  = (op == OP_AND) ? 2'd0 : (op == OP_OR) ? 2'd1 : 2'd2;
    end

    alu8_addsub #(.DATA_W(DATA_W), .NIB_W(4)) i_addsub (
        .a_i(acc_q), .b_i(operand_i), .cin_i(cin), .sub_i(is_sub),
        .sum_o(as_sum), .cy_o(as_cy), .ac_o(as_ac)
    );

    alu8_logic #(.DATA_W(DATA_W)) i_logic (
        .a_i(acc_q), .b_i(operand_i), .sel_i(lg_sel),
        .res_o(lg_res), .ac_o(lg_ac), .cy_o(lg_cy)
    );

    alu8_szp #(.DATA_W(DATA_W)) i_szp (
        .res_i(result_o), .s_o(f_s), .z_o(f_z), .p_o(f_p)
    );

    // Result mux, writeback and flag-update decisions per operation class.
    always_comb begin
        result_o = acc_q;
        acc_we_o = 1'b0;
        flg_we   = 1'b0;
        nxt_cy   = 1'b0;
        nxt_ac   = 1'b0;
        case (op)
            OP_MOV: begin
                result_o = operand_i;
                acc_we_o = 1'b1;
            end
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                result_o = as_sum;
                acc_we_o = 1'b1;
                flg_we   = 1'b1;
                nxt_cy   = as_cy;
                nxt_ac   = as_ac;
            end
            OP_CMP: begin
                result_o = as_sum;
                flg_we   = 1'b1;
                nxt_cy   = as_cy;
                nxt_ac   = as_ac;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result_o = lg_res;
                acc_we_o = 1'b1;
                flg_we   = 1'b1;
                nxt_cy   = lg_cy;
                nxt_ac   = lg_ac;
            end
            default: ;
        endcase
    end

    // Accumulator register: loads on a strobed writing operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (valid_i && acc_we_o)
            acc_q <= result_o;
    end

    // Flag register: loads on a strobed flag-setting operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flg_q <= '0;
        else if (valid_i && flg_we) begin
            flg_q[FLG_S]  <= f_s;
            flg_q[FLG_Z]  <= f_z;
            flg_q[FLG_AC] <= nxt_ac;
            flg_q[FLG_P]  <= f_p;
            flg_q[FLG_CY] <= nxt_cy;
        end
    end

    assign acc_o   = acc_q;
    assign flags_o = flg_q;
endmodule

// File: rtl/alu8_core_chk.sv
// Checker: temporal properties on the ALU's ports, bound into alu8_core.
// Assumes the flag packing and operation codes of alu8_pkg.
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] acc_o,
    input logic [FLAG_W-1:0] flags_o
);
    logic writes_szp;
    // Operations whose committed result equals the new accumulator.
    always_comb writes_szp = valid_i && (op_i != 4'd0) && (op_i != 4'd5) && (op_i <= 4'd8);

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (acc_o == '0) && (flags_o == '0));

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(acc_o) && $stable(flags_o));

    p_cmp_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd5) |=> acc_o == $past(acc_o));

    p_and_carries_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd6) |=> flags_o[FLG_AC] && !flags_o[FLG_CY]);

    p_xor_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd8) |=> !flags_o[FLG_AC] && !flags_o[FLG_CY]);

    p_szp_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        writes_szp |=> (flags_o[FLG_S] == acc_o[DATA_W-1])
                    && (flags_o[FLG_Z] == (acc_o == '0))
                    && (flags_o[FLG_P] == ~(^acc_o)));

    p_move_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd0) |=> flags_o == $past(flags_o));
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .acc_o(acc_o), .flags_o(flags_o)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] operand_i = 8'd0;
    logic [7:0] result_o, acc_o;
    logic       acc_we_o;
    logic [4:0] flags_o;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu8_core i_alu8_core (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .operand_i(operand_i), .result_o(result_o), .acc_we_o(acc_we_o),
        .acc_o(acc_o), .flags_o(flags_o)
    );

    // {op, operand, expected acc, expected flags {S,Z,AC,P,CY}}
    localparam int NV = 18;
    localparam logic [27:0] VEC [NV] = '{
        {4'd0, 8'h87, 8'h87, 8'h00},  // R9 move
        {4'd1, 8'h79, 8'h00, 8'h0F},  // R3 87+79 wraps
        {4'd2, 8'h05, 8'h06, 8'h02},  // R3 carry in
        {4'd3, 8'h10, 8'hF6, 8'h13},  // R4 borrow
        {4'd4, 8'h05, 8'hF0, 8'h12},  // R4 borrow in
        {4'd5, 8'hF0, 8'hF0, 8'h0A},  // R5 equal
        {4'd5, 8'hF1, 8'hF0, 8'h17},  // R5 less
        {4'd6, 8'h3C, 8'h30, 8'h06},  // R6
        {4'd7, 8'h05, 8'h35, 8'h02},  // R7 or
        {4'd8, 8'h35, 8'h00, 8'h0A},  // R7 xor self
        {4'd0, 8'hFF, 8'hFF, 8'h0A},  // R9 flags kept
        {4'd7, 8'hFF, 8'hFF, 8'h12},  // R8 or self
        {4'd1, 8'h01, 8'h00, 8'h0F},  // R3 nibble carry
        {4'd4, 8'h00, 8'hFF, 8'h17},  // R4 borrow only
        {4'd8, 8'h0F, 8'hF0, 8'h12},  // R7 xor
        {4'd6, 8'h0F, 8'h00, 8'h0E},  // R6 zero
        {4'd1, 8'h7F, 8'h7F, 8'h00},  // R8 odd parity
        {4'd2, 8'h80, 8'hFF, 8'h12}   // R3 no carry in
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] op, input logic [7:0] b);
        @(negedge clk);
        valid_i = v; op_i = op; operand_i = b;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset acc", {8'h0, acc_o}, 16'h0);
        chk("R1 reset flags", {11'h0, flags_o}, 16'h0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][27:24], VEC[i][23:16]);
            chk($sformatf("vec%0d acc", i), {8'h0, acc_o}, {8'h0, VEC[i][15:8]});
            chk($sformatf("vec%0d flags", i), {11'h0, flags_o}, {11'h0, VEC[i][4:0]});
        end
        // acc=FF flags=12 now. R2: strobe low
        step(1'b0, 4'd1, 8'h01);
        chk("R2 idle acc", {8'h0, acc_o}, 16'h00FF);
        chk("R2 idle flags", {11'h0, flags_o}, 16'h0012);
        // R2: unused code
        step(1'b1, 4'd12, 8'h01);
        chk("R2 bad op acc", {8'h0, acc_o}, 16'h00FF);
        chk("R2 bad op flags", {11'h0, flags_o}, 16'h0012);
        // R10/R5: combinational outputs
        @(negedge clk);
        op_i = 4'd5; operand_i = 8'h0F; #1;
        chk("R10 R5 cmp result", {8'h0, result_o}, 16'h00F0);
        chk("R5 cmp no write", {15'h0, acc_we_o}, 16'h0);
        op_i = 4'd1; operand_i = 8'h02; #1;
        chk("R10 add result", {8'h0, result_o}, 16'h0001);
        chk("R10 add write", {15'h0, acc_we_o}, 16'h1);
        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rerun acc", {8'h0, acc_o}, 16'h0);
        chk("R1 rerun flags", {11'h0, flags_o}, 16'h0);
        rst_n = 1'b1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule